// File: doc/BRIEF.md
# Request/Acknowledge Byte Shift Engine

This block carries one byte at a time between a host and an external power-management controller. Each transfer is framed by a pair of active-low handshake wires: a request that the engine drives and an acknowledge that the far side drives. The host gives a start pulse together with a direction and, when sending, a data byte. The engine then pulls request low. It moves eight bits MSB first on the rising edges of a shift clock that the far side generates. After the eighth edge it lets request go high and waits for acknowledge to return high.

The wait for acknowledge has a fixed limit in clock cycles. If acknowledge comes back in time, the engine gives a one-cycle done pulse tagged with the direction, and for a receive it holds the captured byte. If the wait runs out, the engine gives a one-cycle timeout pulse instead. If acknowledge is not asserted when the eighth edge lands, the engine raises a one-cycle warning and carries on. The shift clock, the serial input and acknowledge all come from another clock domain, so each one passes through a two-flop synchronizer before it is used.

Top module: `hs_byte_engine`

## Requirements
- R1: After reset, `req_n` and `sdo` are 1, `busy`, `done`, `done_tx`, `timeout_err` and `ack_warn` are 0, and `rx_data` is 0.
- R2: A `start` pulse seen while `busy` is 0 drives `req_n` low and `busy` high from the next cycle. A `start` seen while `busy` is 1 has no effect on the transfer in progress.
- R3: When sending (`start_tx` = 1), `sdo` shows bit DATA_W-1 of the loaded byte first. It moves to the next lower bit one cycle after each synchronized rising shift-clock edge is detected.
- R4: When receiving (`start_tx` = 0), `sdi` is sampled on each synchronized rising shift-clock edge, MSB first. `rx_data` takes the assembled byte in the cycle request is released and keeps it until the next receive completes, including through sends.
- R5: The engine releases `req_n` (drives it high) in the cycle that follows the detection of the eighth rising shift-clock edge.
- R6: In the release phase, a synchronized high `ack_n` ends the transfer with a one-cycle `done` pulse. `done_tx` then shows the direction: 1 for send, 0 for receive.
- R7: If `ack_n` stays low for WAIT_CYCLES cycles of the release phase, `timeout_err` pulses for one cycle. No `done` is produced and the engine returns to idle.
- R8: If the synchronized `ack_n` is high when the eighth edge is taken, `ack_warn` pulses for one cycle as the release phase begins, and the transfer still completes.
- R9: `ack_n`, `sclk` and `sdi` pass through two synchronizer flops. A rise of `ack_n` during release appears as `done` three clock edges later.
- R10: Rising shift-clock edges while idle or in the release phase do not move the shift register. A byte loaded after such edges is still sent intact from its MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer; accepted only while idle |
| start_tx | input | 1 | Direction for the transfer: 1 send, 0 receive |
| tx_data | input | DATA_W | Byte to send, taken with `start` |
| req_n | output | 1 | Transfer request to the far side, active low |
| ack_n | input | 1 | Acknowledge from the far side, active low, asynchronous |
| sclk | input | 1 | Shift clock from the far side, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out; 1 when not sending |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_tx | output | 1 | Direction of the last completed transfer |
| rx_data | output | DATA_W | Last byte received |
| timeout_err | output | 1 | One-cycle pulse when the acknowledge wait runs out |
| ack_warn | output | 1 | One-cycle pulse when acknowledge was not asserted at the eighth edge |

## Verification
A wrong engine state shows on the ports almost at once. `req_n` and `busy` disagree with the handshake phase within one cycle. A stuck or skipped bit count moves the release of `req_n` by a whole shift-clock period. An off-by-one in the wait counter moves `timeout_err` by exactly one cycle against a model that counts release cycles. A shift register disturbed during idle or release appears on `sdo` at the first bit of the next send. A capture taken at the wrong edge appears in `rx_data` the cycle request is released.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_SHIFT   = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;

  // True on the last permitted cycle of a bounded wait.
  function automatic logic limit_reached(input int unsigned count,
                                         input int unsigned limit);
    return (count + 1) >= limit;
  endfunction

  // Next shift-register value: shift left, fill the LSB.
  function automatic logic [31:0] shift_fill(input logic [31:0] value,
                                             input logic fill_bit);
    return {value[30:0], fill_bit};
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hs_shifter.sv
module hs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic         tx_mode,
  input  logic         edge_i,
  input  logic         sdi_i,
  output logic [W-1:0] shreg_o,
  output logic [W-1:0] next_o,
  output logic         last_edge_o
);
  import hs_pkg::*;

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;
  logic             take;
  logic [31:0]      wide_next;

  assign take        = en && edge_i;
  assign wide_next   = shift_fill(32'(shreg), tx_mode ? 1'b0 : sdi_i);
  assign next_o      = wide_next[W-1:0];
  assign last_edge_o = take && (cnt == LAST);
  assign shreg_o     = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (load) begin
      shreg <= load_val;
      cnt   <= '0;
    end else if (take) begin
      shreg <= next_o;
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
  parameter int LIMIT = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          halt,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o
);
  import hs_pkg::*;

  logic [CW-1:0] cnt;

  assign expired_o = run && limit_reached(32'(cnt), LIMIT);
  assign cnt_o     = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (run && !halt)  cnt <= cnt + 1'b1;
    else                    cnt <= '0;
  end
endmodule

// File: rtl/hs_byte_engine.sv
module hs_byte_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYCLES = 6_400_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_tx,
  input  logic [DATA_W-1:0] tx_data,
  output logic              req_n,
  input  logic              ack_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  output logic              done,
  output logic              done_tx,
  output logic [DATA_W-1:0] rx_data,
  output logic              timeout_err,
  output logic              ack_warn
);
  import hs_pkg::*;

  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);

  hs_state_e         state;
  logic              dir_tx;
  logic              sclk_s, sdi_s, ack_hi;
  logic              sclk_d;
  logic              sclk_rise;
  logic              in_shift, in_release, accept;
  logic [DATA_W-1:0] shift_q, shift_next;
  logic              last_edge;
  logic [WAIT_W-1:0] wait_cnt;
  logic              wait_expired;

  // Cross-domain inputs.
  hs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, sdi, ack_n}),
    .q     ({sclk_s, sdi_s, ack_hi})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise  = sclk_s && !sclk_d;
  assign in_shift   = (state == HS_SHIFT);
  assign in_release = (state == HS_RELEASE);
  assign accept     = (state == HS_IDLE) && start;
  assign busy       = (state != HS_IDLE);

  hs_shifter #(.W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_val    (start_tx ? tx_data : '0),
    .en          (in_shift),
    .tx_mode     (dir_tx),
    .edge_i      (sclk_rise),
    .sdi_i       (sdi_s),
    .shreg_o     (shift_q),
    .next_o      (shift_next),
    .last_edge_o (last_edge)
  );

  hs_wait_timer #(.LIMIT(WAIT_CYCLES), .CW(WAIT_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (in_release),
    .halt      (ack_hi || wait_expired),
    .cnt_o     (wait_cnt),
    .expired_o (wait_expired)
  );

  assign sdo = (in_shift && dir_tx) ? shift_q[DATA_W-1] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= HS_IDLE;
      dir_tx      <= 1'b0;
      req_n       <= 1'b1;
      done        <= 1'b0;
      done_tx     <= 1'b0;
      rx_data     <= '0;
      timeout_err <= 1'b0;
      ack_warn    <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      ack_warn    <= 1'b0;
      unique case (state)
        HS_IDLE: begin
          if (start) begin
            state  <= HS_SHIFT;
            dir_tx <= start_tx;
            req_n  <= 1'b0;
          end
        end
        HS_SHIFT: begin
          if (last_edge) begin
            state    <= HS_RELEASE;
            req_n    <= 1'b1;
            ack_warn <= ack_hi;
            if (!dir_tx) rx_data <= shift_next;
          end
        end
        HS_RELEASE: begin
          if (ack_hi) begin
            state   <= HS_IDLE;
            done    <= 1'b1;
            done_tx <= dir_tx;
          end else if (wait_expired) begin
            state       <= HS_IDLE;
            timeout_err <= 1'b1;
          end
        end
        default: state <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_byte_engine_chk.sv
module hs_byte_engine_chk #(
  parameter int DATA_W      = 8,
  parameter int WAIT_CYCLES = 16,
  parameter int WAIT_W      = $clog2(WAIT_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              req_n,
  input logic              done,
  input logic              timeout_err,
  input logic              ack_warn,
  input logic [DATA_W-1:0] rx_data,
  input logic              in_shift,
  input logic              in_release,
  input logic [DATA_W-1:0] shift_q,
  input logic [WAIT_W-1:0] wait_cnt
);
  AST_IDLE_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_n); // R1

  AST_START_DRIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (!req_n && in_shift)); // R2

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_shift |=> $stable(rx_data)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_FROM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(in_release))); // R6

  AST_TMO_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!done && !busy)); // R7

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt < WAIT_W'(WAIT_CYCLES)); // R7

  AST_WARN_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ack_warn |-> (in_release && req_n)); // R8

  AST_RELEASE_HOLDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_release |=> $stable(shift_q)); // R10
endmodule

bind hs_byte_engine hs_byte_engine_chk #(
  .DATA_W      (DATA_W),
  .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (.*);

// File: tb/tb_hs_byte_engine.sv
module tb_hs_byte_engine;
  localparam int W   = 8;
  localparam int LIM = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, start, start_tx, ack_n, sclk, sdi;
  logic [W-1:0] tx_data;
  logic         req_n, sdo, busy, done, done_tx, timeout_err, ack_warn;
  logic [W-1:0] rx_data;

  hs_byte_engine #(.DATA_W(W), .SYNC_STAGES(2), .WAIT_CYCLES(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tx(start_tx),
    .tx_data(tx_data), .req_n(req_n), .ack_n(ack_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .busy(busy), .done(done), .done_tx(done_tx),
    .rx_data(rx_data), .timeout_err(timeout_err), .ack_warn(ack_warn)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  int cyc    = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int   m_phase, m_nedge, m_wait, m_byte;
  bit   m_req, m_tx, m_done, m_dtx, m_tmo, m_warn, m_sdo;
  int   m_rx;
  bit   c1, c2, c3, d1, d2, a1, a2;

  always @(posedge clk) begin
    bit rise, sd, ah;
    if (!rst_n) begin
      m_phase = 0; m_nedge = 0; m_wait = 0; m_byte = 0; m_rx = 0;
      m_req = 1; m_tx = 0; m_done = 0; m_dtx = 0; m_tmo = 0; m_warn = 0;
      c1 = 0; c2 = 0; c3 = 0; d1 = 0; d2 = 0; a1 = 0; a2 = 0;
    end else begin
      rise = c2 && !c3; sd = d2; ah = a2;
      m_done = 0; m_tmo = 0; m_warn = 0;
      if (m_phase == 0) begin
        if (start) begin
          m_phase = 1; m_req = 0; m_tx = start_tx; m_nedge = 0;
          m_byte = start_tx ? int'(tx_data) : 0;
        end
      end else if (m_phase == 1) begin
        if (rise) begin
          m_byte = ((m_byte * 2) + (m_tx ? 0 : int'(sd))) % 256;
          m_nedge++;
          if (m_nedge == W) begin
            m_phase = 2; m_req = 1; m_warn = ah; m_wait = 0;
            if (!m_tx) m_rx = m_byte;
          end
        end
      end else begin
        if (ah) begin
          m_done = 1; m_dtx = m_tx; m_phase = 0;
        end else if (m_wait == LIM - 1) begin
          m_tmo = 1; m_phase = 0;
        end else m_wait++;
      end
      c3 = c2; c2 = c1; c1 = sclk;
      d2 = d1; d1 = sdi;
      a2 = a1; a1 = ack_n;
    end
    m_sdo = (m_phase == 1 && m_tx) ? ((m_byte >> (W - 1)) & 1) : 1'b1;
  end

  int n_done = 0, n_tmo = 0, n_warn = 0;

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check(req_n === m_req,              "R5 req_n vs model",      req_n, m_req);
      check(busy === (m_phase != 0),      "R2 busy vs model",       busy, m_phase != 0);
      check(sdo === m_sdo,                "R3 sdo vs model",        sdo, m_sdo);
      check(rx_data === W'(m_rx),         "R4 rx_data vs model",    rx_data, m_rx);
      check(done === m_done,              "R6 done vs model",       done, m_done);
      check(done_tx === m_dtx,            "R6 done_tx vs model",    done_tx, m_dtx);
      check(timeout_err === m_tmo,        "R7 timeout vs model",    timeout_err, m_tmo);
      check(ack_warn === m_warn,          "R8 ack_warn vs model",   ack_warn, m_warn);
      if (done) n_done++;
      if (timeout_err) n_tmo++;
      if (ack_warn) n_warn++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One byte transfer driven the way the far side would.
  task automatic xfer(input bit tx, input logic [W-1:0] val, input logic [W-1:0] rxpat,
                      input bit assert_ack, input bit release_ack, input bit poke,
                      output logic [W-1:0] seen, output int dd, output int dt, output int dw);
    int b_done, b_tmo, b_warn;
    b_done = n_done; b_tmo = n_tmo; b_warn = n_warn;
    seen = '0;
    @(negedge clk);
    start = 1; start_tx = tx; tx_data = val;
    @(negedge clk);
    start = 0;
    check(req_n === 1'b0 && busy === 1'b1, "R2 request asserted after start", {req_n, busy}, 2'b01);
    if (assert_ack) ack_n = 0;
    for (int i = 0; i < W; i++) begin
      if (poke && i == 3) begin
        start = 1; start_tx = 0; tx_data = ~val;
        @(negedge clk);
        start = 0;
      end
      sdi = rxpat[W-1-i];
      waitn(3);
      seen[W-1-i] = sdo;
      sclk = 1;
      waitn(3);
      sclk = 0;
      if (i < W - 1) waitn(3);
    end
    if (assert_ack) begin
      check(req_n === 1'b1, "R5 request released after last edge", req_n, 1);
      // R10: a shift-clock edge during release must be ignored
      sclk = 1; waitn(3); sclk = 0; waitn(3);
      if (release_ack) begin
        ack_n = 1;
        @(negedge clk); check(done === 1'b0, "R9 done too early (1)", done, 0);
        @(negedge clk); check(done === 1'b0, "R9 done too early (2)", done, 0);
        @(negedge clk); check(done === 1'b1, "R9 done after two sync flops", done, 1);
      end else begin
        for (int k = 0; k < 40 && busy; k++) @(negedge clk);
        ack_n = 1;
      end
    end else begin
      for (int k = 0; k < 10 && busy; k++) @(negedge clk);
    end
    waitn(3);
    #1;
    dd = n_done - b_done; dt = n_tmo - b_tmo; dw = n_warn - b_warn;
  endtask

  initial begin
    logic [W-1:0] seen;
    int dd, dt, dw;
    rst_n = 0; start = 0; start_tx = 0; tx_data = '0;
    ack_n = 1; sclk = 0; sdi = 0;
    waitn(5);
    check(req_n === 1'b1 && sdo === 1'b1, "R1 reset req_n/sdo", {req_n, sdo}, 2'b11);
    check({busy, done, done_tx, timeout_err, ack_warn} === 5'b0, "R1 reset flags",
          {busy, done, done_tx, timeout_err, ack_warn}, 0);
    check(rx_data === '0, "R1 reset rx_data", rx_data, 0);
    rst_n = 1;
    waitn(2);
    check(req_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {req_n, busy}, 2'b10);

    xfer(1, 8'hA5, 8'h00, 1, 1, 0, seen, dd, dt, dw);
    check(seen === 8'hA5, "R3 send A5 MSB first", seen, 8'hA5);
    check(dd == 1 && dt == 0, "R6 one done on send", dd, 1);
    check(done_tx === 1'b1, "R6 direction tag send", done_tx, 1);

    xfer(0, 8'h00, 8'h3C, 1, 1, 0, seen, dd, dt, dw);
    check(rx_data === 8'h3C, "R4 receive 3C", rx_data, 8'h3C);
    check(done_tx === 1'b0 && dd == 1, "R6 direction tag receive", {done_tx, dd[0]}, 2'b01);

    xfer(1, 8'h5A, 8'h00, 1, 1, 1, seen, dd, dt, dw);
    check(seen === 8'h5A, "R2 start while busy ignored", seen, 8'h5A);

    xfer(0, 8'h00, 8'hC3, 1, 0, 0, seen, dd, dt, dw);
    check(dt == 1, "R7 timeout pulse count", dt, 1);
    check(dd == 0, "R7 no done on timeout", dd, 0);
    check(busy === 1'b0 && req_n === 1'b1, "R7 idle after timeout", {busy, req_n}, 2'b01);
    check(rx_data === 8'hC3, "R4 byte captured before timeout", rx_data, 8'hC3);

    xfer(1, 8'h0F, 8'h00, 0, 1, 0, seen, dd, dt, dw);
    check(dw == 1, "R8 warning when ack not asserted", dw, 1);
    check(dd == 1 && seen === 8'h0F, "R8 transfer still completes", {dd[0], seen}, {1'b1, 8'h0F});

    for (int k = 0; k < 3; k++) begin
      sclk = 1; waitn(4); sclk = 0; waitn(4);
    end
    check(busy === 1'b0 && sdo === 1'b1, "R10 idle edges ignored", {busy, sdo}, 2'b01);
    xfer(1, 8'h81, 8'h00, 1, 1, 0, seen, dd, dt, dw);
    check(seen === 8'h81, "R10 byte intact after idle edges", seen, 8'h81);

    xfer(0, 8'h00, 8'hFF, 1, 1, 0, seen, dd, dt, dw);
    check(rx_data === 8'hFF, "R4 receive FF", rx_data, 8'hFF);
    xfer(0, 8'h00, 8'h00, 1, 1, 0, seen, dd, dt, dw);
    check(rx_data === 8'h00, "R4 receive 00", rx_data, 8'h00);
    xfer(1, 8'h66, 8'hFF, 1, 1, 0, seen, dd, dt, dw);
    check(rx_data === 8'h00, "R4 rx_data held across send", rx_data, 8'h00);
    check(seen === 8'h66, "R3 send 66", seen, 8'h66);

    waitn(4);
    finish_run();
  end
endmodule